// File: doc/BRIEF.md
# Write-Only Block-Mode Two-Wire Configuration Slave

This block is a serial slave on a two-wire (I2C-style) bus that takes writes only. It oversamples the bus clock and data lines with the system clock, finds START and STOP conditions, and checks the first byte against its write address (0xD2). On a match it acknowledges by pulling the data line low during the ninth bus clock. It then loads a small bank of 8-bit control registers, whose contents are presented in parallel to the surrounding logic.

After the address, the master sends two header bytes: a command code and a byte count. Both are acknowledged and then dropped. Each byte after them goes into the next register in sequence, starting at register 0. There is no sub-addressing, so to reach a later register every earlier one has to be written again. A register changes only once all eight of its bits have arrived. Bytes past the storage or past the data limit get no acknowledge. Reads, other addresses and clock stretching are not supported.

Top module: `cfg_wr_slave`

## Requirements
- R1: After a synchronous active-low reset, all registers read 0x00 and the pull-down enable `sda_pull` is low.
- R2: A first byte of 0xD2 (7-bit address 0x69 with R/W bit 0 = write) is acknowledged. The data line is held low for the whole high phase of the ninth bus clock, and the pull-down is only switched on while the bus clock is low.
- R3: Any other first byte, including the read form 0xD3, gets no acknowledge, and no register changes for the rest of that transaction.
- R4: The two bytes that follow an accepted address are acknowledged and never stored in any register.
- R5: Data bytes are received most significant bit first and are stored in order: the first into register 0, the second into register 1, and so on. Registers that are not written keep their values.
- R6: A data byte at position 7 or later (beyond the 6-byte limit, or beyond the number of registers if that is smaller) gets no acknowledge and is dropped. No further byte in that transaction is acknowledged.
- R7: A STOP in the middle of a byte leaves the register that byte was headed for unchanged, and releases the data line.
- R8: A START seen in the middle of a byte clears the bit count and the byte position. The next transaction therefore starts again with an address byte and writes from register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_pull | output | 1 | Drive the data line low (acknowledge) when high |
| regs_flat | output | NUM_REGS*8 | Register contents, register i at bits [8i+7:8i] |

## Verification
The bench sends a seventh data byte. A design that does not count the limit correctly would acknowledge it, or would wrap around and overwrite register 0. It cuts a byte short with a STOP and, separately, with a repeated START. A design that stored partial shifts, or did not clear the bit and byte counters, would corrupt a register or shift the write positions of the next transaction by one. It sends the read address and a foreign address followed by data. A design that kept listening would acknowledge those bytes or change registers. Writes with only the header, or with a single 0x80 byte, show whether the header bytes are dropped and whether bits are taken MSB first.

// File: rtl/cfgw_pkg.sv
// Shared types for the write-only configuration slave.
package cfgw_pkg;
    // Receive engine states
    typedef enum logic [2:0] {
        ST_IDLE,       // waiting for START
        ST_RX,         // shifting in bits of a byte
        ST_WAIT_FALL,  // byte complete, waiting for SCL low to place ACK
        ST_ACK,        // driving ACK through the ninth clock
        ST_SKIP        // not addressed or overflowed, ignore until START/STOP
    } rx_state_t;
endpackage

// File: rtl/cfgw_line_sampler.sv
// Synchronises SCL and SDA to the system clock and derives events.
// Assumes the system clock is several times faster than SCL so that every
// bus phase spans at least a few samples. Both lines idle high.
module cfgw_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic                   scl_prev;
    logic                   sda_prev;

    // Synchronizer chains plus one history stage for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_prev  <= 1'b1;
            sda_prev  <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_in};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_in};
            scl_prev  <= scl_chain[SYNC_STAGES-1];
            sda_prev  <= sda_chain[SYNC_STAGES-1];
        end
    end

    // Event decode from current and previous synchronized levels
    always_comb begin
        scl_lvl   = scl_chain[SYNC_STAGES-1];
        sda_lvl   = sda_chain[SYNC_STAGES-1];
        scl_rise  = scl_lvl && !scl_prev;
        scl_fall  = !scl_lvl && scl_prev;
        start_det = scl_lvl && scl_prev && sda_prev && !sda_lvl;
        stop_det  = scl_lvl && scl_prev && !sda_prev && sda_lvl;
    end
endmodule

// File: rtl/cfgw_byte_engine.sv
// Bit and byte sequencer: shifts bytes MSB first, decides ACK per byte,
// and issues register writes for accepted data bytes.
// Assumes clean events from the line sampler; START or STOP always wins.
module cfgw_byte_engine
    import cfgw_pkg::*;
#(
    parameter logic [7:0] DEV_BYTE = 8'hD2,
    parameter int PREAMBLE = 2,
    parameter int MAX_DATA = 6,
    parameter int NUM_REGS = 6,
    localparam int LIMIT   = (NUM_REGS < MAX_DATA) ? NUM_REGS : MAX_DATA,
    localparam int REG_IW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int IDX_W   = $clog2(PREAMBLE + NUM_REGS + MAX_DATA + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [REG_IW-1:0] wr_idx,
    output logic [7:0]        wr_data
);
    localparam logic [IDX_W-1:0] PRE_LAST   = IDX_W'(PREAMBLE);
    localparam logic [IDX_W-1:0] FIRST_DATA = IDX_W'(PREAMBLE + 1);
    localparam logic [IDX_W-1:0] SLOT_LIM   = IDX_W'(LIMIT);
    localparam logic [IDX_W-1:0] IDX_MAX    = '1;

    rx_state_t        state;
    logic [2:0]       bitcnt;
    logic [7:0]       shreg;
    logic [IDX_W-1:0] byte_idx;
    logic             ack_pend;
    logic [7:0]       shift_nxt;
    logic [IDX_W-1:0] data_slot;
    logic             byte_end;
    logic             is_data;
    logic             accept;

    // Next shift value, byte position decode and ACK decision
    always_comb begin
        shift_nxt = {shreg[6:0], sda_lvl};
        data_slot = byte_idx - FIRST_DATA;
        byte_end  = (state == ST_RX) && scl_rise && (bitcnt == 3'd7);
        is_data   = (byte_idx >= FIRST_DATA);
        if (byte_idx == '0)
            accept = (shift_nxt == DEV_BYTE);
        else if (byte_idx <= PRE_LAST)
            accept = 1'b1;
        else
            accept = (data_slot < SLOT_LIM);
    end

    // Receive state machine with bit and byte counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            byte_idx <= '0;
            ack_pend <= 1'b0;
        end else if (start_det) begin
            state    <= ST_RX;
            bitcnt   <= '0;
            byte_idx <= '0;
            ack_pend <= 1'b0;
        end else if (stop_det) begin
            state    <= ST_IDLE;
            bitcnt   <= '0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise) begin
                        shreg <= shift_nxt;
                        if (bitcnt == 3'd7) begin
                            bitcnt   <= '0;
                            ack_pend <= accept;
                            state    <= ST_WAIT_FALL;
                        end else begin
                            bitcnt <= bitcnt + 3'd1;
                        end
                    end
                end
                ST_WAIT_FALL: begin
                    if (scl_fall) state <= ack_pend ? ST_ACK : ST_SKIP;
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        state <= ST_RX;
                        if (byte_idx != IDX_MAX) byte_idx <= byte_idx + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs: ACK drive and register write strobe
    always_comb begin
        sda_pull = (state == ST_ACK);
        wr_en    = byte_end && is_data && accept;
        wr_idx   = data_slot[REG_IW-1:0];
        wr_data  = shift_nxt;
    end

    // R2: the data line is only grabbed while the bus clock is low
    p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_lvl);
    // R8: a START restarts bit and byte counting
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (bitcnt == 3'd0 && byte_idx == '0 && state == ST_RX));
    // R7: a STOP releases the line and parks the engine
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_pull && state == ST_IDLE));
    // R4: header positions never reach the register bank
    p_header_not_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_end && byte_idx <= PRE_LAST) |-> !wr_en);
endmodule

// File: rtl/cfgw_reg_bank.sv
// Bank of byte registers written one at a time by index.
// Assumes at most one write per cycle; index is pre-checked by the engine.
module cfgw_reg_bank #(
    parameter int NUM_REGS = 6,
    localparam int REG_IW  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_IW-1:0]     wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [7:0] val;
        // Register g loads only on a write addressed to it
        always_ff @(posedge clk) begin
            if (!rst_n)
                val <= 8'h00;
            else if (wr_en && wr_idx == REG_IW'(g))
                val <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = val;
    end

    // R1: reset clears the whole bank
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (regs_flat == '0));
    // R6: writes only land inside the implemented bank
    p_idx_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_idx) < NUM_REGS));
    // R5: without a write the bank holds its contents
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_flat));
endmodule

// File: rtl/cfg_wr_slave.sv
// Top of the write-only two-wire configuration slave: sampler, byte
// sequencer and register bank. sda_pull is an open-drain enable; the pad
// ring drives the line low when it is high.
module cfg_wr_slave #(
    parameter logic [7:0] DEV_BYTE = 8'hD2,
    parameter int NUM_REGS    = 6,
    parameter int MAX_DATA    = 6,
    parameter int PREAMBLE    = 2,
    parameter int SYNC_STAGES = 2,
    localparam int REG_IW     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_in,
    input  logic                  sda_in,
    output logic                  sda_pull,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [REG_IW-1:0] wr_idx;
    logic [7:0]        wr_data;

    cfgw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) i_sampler (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    cfgw_byte_engine #(
        .DEV_BYTE(DEV_BYTE), .PREAMBLE(PREAMBLE),
        .MAX_DATA(MAX_DATA), .NUM_REGS(NUM_REGS)
    ) i_engine (
        .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .sda_pull(sda_pull), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data)
    );

    cfgw_reg_bank #(.NUM_REGS(NUM_REGS)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .regs_flat(regs_flat)
    );
endmodule

// File: tb/test_cfg_wr_slave.sv
// Bench: table of write transactions checked against a reference model,
// then directed tests for reset, truncated bytes and repeated START.
module test_cfg_wr_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 6;
    localparam int Q = 6;    // system clocks per quarter bus bit
    localparam int NVEC = 7;
    // {first byte, data count, up to 8 data bytes (first at MSBs)}
    localparam logic [75:0] VEC [NVEC] = '{
        {8'hD2, 4'd3, 64'hA1B2C3_0000000000},
        {8'hD2, 4'd6, 64'h112233445566_0000},
        {8'hD3, 4'd2, 64'hEEEE_000000000000},
        {8'hA4, 4'd2, 64'h7777_000000000000},
        {8'hD2, 4'd7, 64'h01020304050607_00},
        {8'hD2, 4'd0, 64'h0},
        {8'hD2, 4'd1, 64'h80_00000000000000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    logic [NREG*8-1:0] regs_flat;
    wire  sda_line = sda_m & ~sda_pull;
    logic [7:0] exp_regs [NREG];
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_wr_slave i_cfg_wr_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_pull(sda_pull), .regs_flat(regs_flat)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    // One bit: data set during low, sampled line returned from mid-high
    task automatic put_bit(input logic b, output logic seen);
        sda_m = b; wq(); scl_m = 1'b1; wq(); seen = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) put_bit(v[i], s);
        put_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic check_regs(input string tag);
        for (int k = 0; k < NREG; k++)
            chk(tag, 64'(regs_flat[k*8 +: 8]), 64'(exp_regs[k]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic ack;
        logic s;
        logic ok;
        repeat (4) @(negedge clk);
        // R1: reset state
        for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
        check_regs("R1 reset regs");
        chk("R1 reset sda_pull", 64'(sda_pull), 64'd0);
        rst_n = 1'b1;
        wq();

        for (int t = 0; t < NVEC; t++) begin
            logic [7:0]  fb;
            logic [3:0]  n;
            logic [63:0] dat;
            {fb, n, dat} = VEC[t];
            bus_start();
            put_byte(fb, ack);
            ok = (fb == 8'hD2);
            chk(ok ? "R2 address ack" : "R3 foreign address nack", 64'(ack), 64'(ok));
            put_byte(8'h5A, ack);
            chk("R4 command byte ack", 64'(ack), 64'(ok));
            put_byte(8'h06, ack);
            chk("R4 count byte ack", 64'(ack), 64'(ok));
            for (int i = 0; i < int'(n); i++) begin
                logic [7:0] v;
                v = dat[63-8*i -: 8];
                put_byte(v, ack);
                if (i >= NREG) ok = 1'b0;
                chk(i >= NREG ? "R6 overflow byte nack" : "R5 data byte ack", 64'(ack), 64'(ok));
                if (ok) exp_regs[i] = v;
            end
            bus_stop();
            chk("R7 line released after stop", 64'(sda_pull), 64'd0);
            check_regs("R5 register contents");
        end

        // R7: STOP after four bits of a data byte leaves register 0 alone
        bus_start();
        put_byte(8'hD2, ack); put_byte(8'h00, ack); put_byte(8'h00, ack);
        for (int i = 0; i < 4; i++) put_bit(1'b1, s);
        bus_stop();
        check_regs("R7 partial byte dropped");

        // R8: repeated START mid-byte, then a fresh write lands in register 0
        bus_start();
        put_byte(8'hD2, ack); put_byte(8'h00, ack); put_byte(8'h00, ack);
        put_byte(8'h3C, ack);
        exp_regs[0] = 8'h3C;
        for (int i = 0; i < 3; i++) put_bit(1'b0, s);
        bus_start();
        put_byte(8'hD2, ack);
        chk("R8 address after restart ack", 64'(ack), 64'd1);
        put_byte(8'h00, ack); put_byte(8'h00, ack);
        put_byte(8'hC5, ack);
        chk("R8 data after restart ack", 64'(ack), 64'd1);
        exp_regs[0] = 8'hC5;
        bus_stop();
        check_regs("R8 restart writes from register 0");

        // R1: reset in mid-operation clears everything again
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NREG; k++) exp_regs[k] = 8'h00;
        check_regs("R1 second reset");
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule